// File: doc/BRIEF.md
# Memory-mapped TLB access port

This block holds the storage of a four-way, 32-entry translation buffer and lets software inspect and rewrite it through ordinary loads and stores. Two fixed windows of the address space reach the storage: the tag window carries the virtual page number, the valid flag and the address-space identifier of an entry, and the attribute window carries the physical page number and the protection, size, cacheable, dirty and shared attributes. The entry and the way are picked by fields of the bus address, so any slot can be reached without a lookup.

When the hash control input is high, the entry field of the address is combined with the low bits of the current address-space identifier by exclusive-or before a slot is chosen. This gives software the same slot that a hashed lookup would use. The valid flag lives once per slot and appears in both windows. Accesses that are not full 32-bit words, that come from user mode or that are instruction fetches are refused. A refused access changes nothing, returns zero and raises an error flag.

Top module: `tlb_window_port`

## Requirements
- R1: A request with address bits 31:24 equal to 0xF2 reaches the tag window. A write stores the virtual page number from bits 31:17, the valid flag from bit 8 and the identifier from bits 7:0, and a read returns them in the same positions.
- R2: A request with address bits 31:24 equal to 0xF3 reaches the attribute window. A write stores the physical page number from bits 28:10, valid from bit 8, protection from bits 6:5, size from bit 4, cacheable from bit 3, dirty from bit 2 and shared from bit 1, and a read returns them in the same positions.
- R3: Address bits 16:12 select one of 32 entries and bits 9:8 select one of four ways. A write to one slot leaves every other slot unchanged.
- R4: While the hash input is high, the entry used is address bits 16:12 XOR the low 5 bits of the current identifier input, and the upper identifier bits have no effect. While it is low, bits 16:12 are used unchanged.
- R5: A window request whose size code is not word (size codes: 0 byte, 1 halfword, 2 word) is refused.
- R6: A window request with the privilege input low is refused.
- R7: A window request with the instruction-fetch input high is refused.
- R8: A refused request raises the error flag together with ready for one cycle, returns zero read data and leaves both arrays unchanged.
- R9: The valid flag of a slot is shared: a write through either window sets or clears it, and reads through both windows show its current value. The other fields of the window not written are kept.
- R10: Every window request gets ready high for exactly the one cycle after the request cycle, with the read data in that cycle. A request outside both windows gets no ready and no error.
- R11: Bit positions not named in R1 and R2 read as zero.
- R12: Reset clears every valid flag and leaves ready, error and read data low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Request strobe, one cycle per access |
| busAddr | input | 32 | Access address: window, entry and way fields |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| busPriv | input | 1 | High for a privileged access |
| busFetch | input | 1 | High for an instruction fetch |
| hashEn | input | 1 | Enables the XOR of the entry index with the identifier |
| curAsid | input | 8 | Current address-space identifier |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | One-cycle response strobe |
| busErr | output | 1 | Access refused, coincides with busReady |

## Verification
The bench writes a slot through one window and reads it back through the other. A design that kept two copies of the valid flag would show a stale flag there, and one that cleared the other window's fields on a write would lose the page number. It checks the hashed index with a write made under hashing and a read made without it, using an identifier whose upper bits are set, so a design that hashed with the wrong bits or ignored the hash control picks the wrong slot. Each refusal cause is sent as a write to a live slot and then read back, which catches a design that reports the error but still commits the data. It also checks stray addresses outside the windows, all-ones writes that show any unused bit leaking through, and a reset in mid-run that must drop valid flags set earlier.

// File: rtl/tlb_window_pkg.sv
package tlb_window_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic tagWr;    // commit write into tag window fields
    logic tagRd;    // capture tag window word
    logic datWr;    // commit write into attribute window fields
    logic datRd;    // capture attribute window word
    logic respond;  // a window request was seen
    logic reject;   // the window request is refused
  } winStrobe_t;

endpackage

// File: rtl/tlb_window_ctrl.sv
module tlb_window_ctrl
  import tlb_window_pkg::*;
#(
  parameter int          IDX_W   = 5,
  parameter int          WAY_W   = 2,
  parameter int          ASID_W  = 8,
  parameter int          IDX_LSB = 12,
  parameter int          WAY_LSB = 8,
  parameter logic [7:0]  TAG_WIN = 8'hF2,
  parameter logic [7:0]  DAT_WIN = 8'hF3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [31:0]       busAddr,
  input  logic              busWe,
  input  logic [1:0]        busSize,
  input  logic              busPriv,
  input  logic              busFetch,
  input  logic              hashEn,
  input  logic [ASID_W-1:0] curAsid,
  output winStrobe_t        stb,
  output logic [IDX_W-1:0]  entrySel,
  output logic [WAY_W-1:0]  waySel,
  output logic              busReady,
  output logic              busErr
);

  logic isTag, isDat, inWin, badAcc, okAcc;
  logic [IDX_W-1:0] hashMask;
  logic unusedBits;

  assign isTag  = busAddr[31:24] == TAG_WIN;
  assign isDat  = busAddr[31:24] == DAT_WIN;
  assign inWin  = busReq && (isTag || isDat);
  assign badAcc = (accSize_e'(busSize) != SZ_WORD) || !busPriv || busFetch;
  assign okAcc  = inWin && !badAcc;

  // optional index hash with the low identifier bits
  assign hashMask = hashEn ? curAsid[IDX_W-1:0] : '0;
  assign entrySel = busAddr[IDX_LSB +: IDX_W] ^ hashMask;
  assign waySel   = busAddr[WAY_LSB +: WAY_W];

  always_comb begin
    stb         = '0;
    stb.respond = inWin;
    stb.reject  = inWin && badAcc;
    stb.tagWr   = okAcc && isTag && busWe;
    stb.tagRd   = okAcc && isTag && !busWe;
    stb.datWr   = okAcc && isDat && busWe;
    stb.datRd   = okAcc && isDat && !busWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReady <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      busReady <= stb.respond;
      busErr   <= stb.reject;
    end
  end

  assign unusedBits = ^{busAddr, curAsid};

endmodule

// File: rtl/tlb_window_store.sv
module tlb_window_store
  import tlb_window_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 15,
  parameter int PPN_W   = 19,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       stb,
  input  logic [IDX_W-1:0] entrySel,
  input  logic [WAY_W-1:0] waySel,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata
);

  localparam int SLOTS    = WAYS * ENTRIES;
  localparam int SLOT_W   = WAY_W + IDX_W;
  localparam int VPN_LSB  = 32 - VPN_W;
  localparam int PPN_LSB  = 10;
  localparam int V_BIT    = 8;
  localparam int ATTR_LSB = 1;
  localparam int ATTR_W   = 6;   // protection(2), size, cacheable, dirty, shared

  logic [VPN_W-1:0]  vpnMem  [SLOTS];
  logic [ASID_W-1:0] asidMem [SLOTS];
  logic [PPN_W-1:0]  ppnMem  [SLOTS];
  logic [ATTR_W-1:0] attrMem [SLOTS];
  logic [SLOTS-1:0]  validVec;

  logic [SLOT_W-1:0] slot;
  logic [31:0]       tagWord, datWord;
  logic              unusedWdata;

  assign slot = {waySel, entrySel};

  // field stores, no reset needed: valid gates their meaning
  always_ff @(posedge clk) begin
    if (stb.tagWr) begin
      vpnMem[slot]  <= busWdata[VPN_LSB +: VPN_W];
      asidMem[slot] <= busWdata[ASID_W-1:0];
    end
    if (stb.datWr) begin
      ppnMem[slot]  <= busWdata[PPN_LSB +: PPN_W];
      attrMem[slot] <= busWdata[ATTR_LSB +: ATTR_W];
    end
  end

  // one shared valid flag per slot, written from either window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validVec <= '0;
    else if (stb.tagWr || stb.datWr) validVec[slot] <= busWdata[V_BIT];
  end

  always_comb begin
    tagWord = '0;
    tagWord[VPN_LSB +: VPN_W] = vpnMem[slot];
    tagWord[V_BIT]            = validVec[slot];
    tagWord[ASID_W-1:0]       = asidMem[slot];
    datWord = '0;
    datWord[PPN_LSB +: PPN_W]   = ppnMem[slot];
    datWord[V_BIT]              = validVec[slot];
    datWord[ATTR_LSB +: ATTR_W] = attrMem[slot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.tagRd) busRdata <= tagWord;
    else if (stb.datRd) busRdata <= datWord;
    else                busRdata <= '0;
  end

  assign unusedWdata = ^busWdata;

endmodule

// File: rtl/tlb_window_port.sv
module tlb_window_port
  import tlb_window_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 15,
  parameter int PPN_W   = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [31:0]       busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  input  logic [1:0]        busSize,
  input  logic              busPriv,
  input  logic              busFetch,
  input  logic              hashEn,
  input  logic [ASID_W-1:0] curAsid,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              busErr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int WAY_W = $clog2(WAYS);

  winStrobe_t       stb;
  logic [IDX_W-1:0] entrySel;
  logic [WAY_W-1:0] waySel;

  tlb_window_ctrl #(
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .ASID_W(ASID_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busReq  (busReq),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busSize (busSize),
    .busPriv (busPriv),
    .busFetch(busFetch),
    .hashEn  (hashEn),
    .curAsid (curAsid),
    .stb     (stb),
    .entrySel(entrySel),
    .waySel  (waySel),
    .busReady(busReady),
    .busErr  (busErr)
  );

  tlb_window_store #(
    .WAYS   (WAYS),
    .ENTRIES(ENTRIES),
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W)
  ) i_store (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .entrySel(entrySel),
    .waySel  (waySel),
    .busWdata(busWdata),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/tlb_window_port_chk.sv
module tlb_window_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busReq,
  input logic [31:0] busAddr,
  input logic        busWe,
  input logic [1:0]  busSize,
  input logic        busPriv,
  input logic        busFetch,
  input logic [31:0] busRdata,
  input logic        busReady,
  input logic        busErr
);

  logic inWin, tagRead, datRead;
  assign inWin   = busReq && (busAddr[31:24] == 8'hF2 || busAddr[31:24] == 8'hF3);
  assign tagRead = busReq && busAddr[31:24] == 8'hF2 && !busWe;
  assign datRead = busReq && busAddr[31:24] == 8'hF3 && !busWe;

  // R10
  ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> busReady) else $error("ready missing after window request");

  // R10
  no_stray_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> !busReady && !busErr) else $error("ready without window request");

  // R5
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin && busSize != 2'd2 |=> busErr) else $error("non-word access not refused");

  // R6
  user_mode_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin && !busPriv |=> busErr) else $error("user access not refused");

  // R7
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWin && busFetch |=> busErr) else $error("fetch not refused");

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busReady && busRdata == 32'h0) else $error("refusal returned data");

  // R11
  tag_unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagRead |=> busRdata[16:9] == 8'h0) else $error("tag word unused bits set");

  // R11
  dat_unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    datRead |=> busRdata[31:29] == 3'h0 && busRdata[9] == 1'b0 &&
                busRdata[7] == 1'b0 && busRdata[0] == 1'b0)
    else $error("attribute word unused bits set");

endmodule

bind tlb_window_port tlb_window_port_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busReq  (busReq),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busSize (busSize),
  .busPriv (busPriv),
  .busFetch(busFetch),
  .busRdata(busRdata),
  .busReady(busReady),
  .busErr  (busErr)
);

// File: tb/test_tlb_window_port.sv
`timescale 1ns/1ps
module test_tlb_window_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [1:0]  busSize = 2'd2;
  logic        busPriv = 1'b1;
  logic        busFetch = 1'b0;
  logic        hashEn = 1'b0;
  logic [7:0]  curAsid = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        busErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  logic [31:0] maskQ[$];
  logic        errQ[$];
  string       tagQ[$];

  localparam logic [7:0] TW = 8'hF2;
  localparam logic [7:0] DW = 8'hF3;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  always #4 clk = ~clk;

  tlb_window_port i_tlb_window_port (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busSize(busSize), .busPriv(busPriv),
    .busFetch(busFetch), .hashEn(hashEn), .curAsid(curAsid),
    .busRdata(busRdata), .busReady(busReady), .busErr(busErr)
  );

  function automatic logic [31:0] addrOf(logic [7:0] win, logic [4:0] idx, logic [1:0] way);
    return {win, 7'b0, idx, 2'b0, way, 8'b0};
  endfunction

  function automatic logic [31:0] aWord(logic [14:0] vpn, logic v, logic [7:0] asid);
    return {vpn, 8'b0, v, asid};
  endfunction

  function automatic logic [31:0] dWord(logic [18:0] ppn, logic v, logic [1:0] pr,
                                        logic sz, logic c, logic d, logic sh);
    return {3'b0, ppn, 1'b0, v, 1'b0, pr, sz, c, d, sh, 1'b0};
  endfunction

  // driver: one request per call, expected response queued for the monitor
  task automatic access(input logic [31:0] addr, input logic [31:0] wdata, input logic we,
                        input logic [1:0] size, input logic priv, input logic fetch,
                        input logic [31:0] exp, input logic [31:0] mask,
                        input logic expErr, input string tag);
    @(negedge clk);
    busReq = 1'b1; busAddr = addr; busWdata = wdata; busWe = we;
    busSize = size; busPriv = priv; busFetch = fetch;
    expQ.push_back(exp); maskQ.push_back(mask); errQ.push_back(expErr); tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] wdata, input string tag);
    access(addr, wdata, 1'b1, 2'd2, 1'b1, 1'b0, 32'h0, ALL, 1'b0, tag);
  endtask

  task automatic rd(input logic [31:0] addr, input logic [31:0] exp, input logic [31:0] mask,
                    input string tag);
    access(addr, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0, exp, mask, 1'b0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0; busSize = 2'd2; busPriv = 1'b1; busFetch = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rstN && busReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 stray ready: actual err=%b rdata=%h expected no response",
                 busErr, busRdata);
      end else begin
        logic [31:0] e, m; logic ee; string t;
        e = expQ.pop_front(); m = maskQ.pop_front(); ee = errQ.pop_front(); t = tagQ.pop_front();
        if (((busRdata ^ e) & m) != 32'h0 || busErr != ee) begin
          errors++;
          $display("FAIL %s: actual rdata=%h err=%b expected rdata=%h err=%b (mask %h)",
                   t, busRdata, busErr, e, ee, m);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL R10 watchdog: actual cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state at the ports
    check(busReady == 1'b0 && busErr == 1'b0, "R12 reset ready/err", {30'b0, busReady, busErr}, 32'h0);
    check(busRdata == 32'h0, "R12 reset rdata", busRdata, 32'h0);
    rd(addrOf(TW, 5'd0, 2'd0), 32'h0, 32'h100, "R12 valid clear after reset");
    rd(addrOf(DW, 5'd31, 2'd3), 32'h0, 32'h100, "R12 valid clear after reset");
    idle();

    // R1 tag window write/read
    wr(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), "R1 tag write");
    rd(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), ALL, "R1 tag readback");
    // R2 attribute window write/read (back to back)
    wr(addrOf(DW, 5'd5, 2'd2), dWord(19'h4_1234, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), "R2 attr write");
    rd(addrOf(DW, 5'd5, 2'd2), dWord(19'h4_1234, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), ALL, "R2 attr readback");
    idle();

    // R9 shared valid flag
    wr(addrOf(DW, 5'd5, 2'd2), dWord(19'h4_1234, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), "R9 clear V via attr");
    rd(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b0, 8'h3C), ALL, "R9 tag shows cleared V");
    wr(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), "R9 set V via tag");
    rd(addrOf(DW, 5'd5, 2'd2), dWord(19'h4_1234, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), ALL, "R9 attr shows set V, fields kept");
    idle();

    // R3 way and entry selection
    wr(addrOf(TW, 5'd5, 2'd1), aWord(15'h1111, 1'b1, 8'h11), "R3 other way write");
    wr(addrOf(TW, 5'd6, 2'd2), aWord(15'h2222, 1'b0, 8'h22), "R3 other entry write");
    wr(addrOf(TW, 5'd31, 2'd3), aWord(15'h7FFF, 1'b1, 8'hFF), "R3 last slot write");
    rd(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), ALL, "R3 slot 5/2 untouched");
    rd(addrOf(TW, 5'd5, 2'd1), aWord(15'h1111, 1'b1, 8'h11), ALL, "R3 slot 5/1");
    rd(addrOf(TW, 5'd6, 2'd2), aWord(15'h2222, 1'b0, 8'h22), ALL, "R3 slot 6/2");
    rd(addrOf(TW, 5'd31, 2'd3), aWord(15'h7FFF, 1'b1, 8'hFF), ALL, "R3 slot 31/3");
    idle();

    // R4 hashed index: 6 ^ 3 = 5, upper identifier bits ignored
    hashEn = 1'b1; curAsid = 8'hE3;
    rd(addrOf(TW, 5'd6, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), ALL, "R4 hashed read hits entry 5");
    wr(addrOf(TW, 5'd0, 2'd0), aWord(15'h0ABC, 1'b1, 8'h03), "R4 hashed write to entry 3");
    idle();
    hashEn = 1'b0;
    rd(addrOf(TW, 5'd3, 2'd0), aWord(15'h0ABC, 1'b1, 8'h03), ALL, "R4 unhashed read of entry 3");
    rd(addrOf(TW, 5'd6, 2'd2), aWord(15'h2222, 1'b0, 8'h22), ALL, "R4 hash off uses raw index");
    idle();

    // R5 R6 R7 R8 refusals: error, zero data, no change
    access(addrOf(TW, 5'd5, 2'd2), ALL, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0, ALL, 1'b1, "R5 byte write refused");
    access(addrOf(DW, 5'd5, 2'd2), 32'h0, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0, ALL, 1'b1, "R5 halfword read refused");
    access(addrOf(TW, 5'd5, 2'd2), 32'h0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0, ALL, 1'b1, "R6 user write refused");
    access(addrOf(DW, 5'd5, 2'd2), 32'h0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0, ALL, 1'b1, "R6 user read refused");
    access(addrOf(DW, 5'd5, 2'd2), 32'h0, 1'b1, 2'd2, 1'b1, 1'b1, 32'h0, ALL, 1'b1, "R7 fetch write refused");
    access(addrOf(TW, 5'd5, 2'd2), 32'h0, 1'b0, 2'd2, 1'b1, 1'b1, 32'h0, ALL, 1'b1, "R7 fetch read refused");
    rd(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), ALL, "R8 tag unchanged after refusals");
    rd(addrOf(DW, 5'd5, 2'd2), dWord(19'h4_1234, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1), ALL, "R8 attr unchanged after refusals");
    idle();

    // R10 requests outside both windows get no response
    @(negedge clk);
    busReq = 1'b1; busAddr = 32'hF400_5200; busWe = 1'b1; busWdata = ALL;
    @(negedge clk);
    busAddr = 32'h1200_0000; busWe = 1'b0;
    check(busReady == 1'b0 && busErr == 1'b0, "R10 no response outside windows", {30'b0, busReady, busErr}, 32'h0);
    @(negedge clk);
    busReq = 1'b0;
    check(busReady == 1'b0 && busErr == 1'b0, "R10 no response outside windows", {30'b0, busReady, busErr}, 32'h0);
    rd(addrOf(TW, 5'd5, 2'd2), aWord(15'h5A5A, 1'b1, 8'h3C), ALL, "R10 stray write had no effect");
    @(negedge clk);
    busReq = 1'b0;
    check(busReady == 1'b1, "R10 ready one cycle after request", {31'b0, busReady}, 32'h1);
    @(negedge clk);
    check(busReady == 1'b0, "R10 ready lasts one cycle", {31'b0, busReady}, 32'h0);
    idle();

    // R11 unused bits read as zero
    wr(addrOf(TW, 5'd9, 2'd0), ALL, "R11 tag all ones");
    wr(addrOf(DW, 5'd9, 2'd0), ALL, "R11 attr all ones");
    rd(addrOf(TW, 5'd9, 2'd0), 32'hFFFE_01FF, ALL, "R11 tag unused bits zero");
    rd(addrOf(DW, 5'd9, 2'd0), 32'h1FFF_FD7E, ALL, "R11 attr unused bits zero");
    idle();

    // R12 reset in mid-run drops valid flags
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(addrOf(TW, 5'd5, 2'd2), 32'h0, 32'h100, "R12 valid cleared by reset");
    rd(addrOf(DW, 5'd31, 2'd3), 32'h0, 32'h100, "R12 valid cleared by reset");
    idle();
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R10 every request answered", expQ.size(), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule